// File: doc/BRIEF.md
# BCD Decimal Adjust Accumulator Slice

This block is the arithmetic slice of a small accumulator datapath. It holds an 8-bit accumulator and two flags: a carry flag (CY) out of the top bit and an auxiliary carry flag (AC) out of the low nibble. Each accepted command either adds an operand byte to the accumulator, adds it together with the current carry, or applies a decimal-adjust step. The adjust step turns the binary sum of two packed-BCD bytes back into a valid packed-BCD byte.

A caller presents a command code and an operand with a valid strobe. The result is in the registers after that clock edge. Subtraction, overflow detection, multiply and divide are not part of this slice, and operands are not checked for BCD validity.

Top module: `bcd_acc_slice`

## Requirements
- R1: After an asynchronous active-low reset, the accumulator, CY and AC all read 0.
- R2: Command code 2'b00 (plain add) loads the accumulator with (acc + operand) mod 256. CY takes the carry out of bit 7 and AC takes the carry out of bit 3.
- R3: Command code 2'b01 (add with carry) behaves like R2, with the current CY added in as a third term. For example, 05h + 03h with CY=1 gives 09h.
- R4: Command code 2'b10 (decimal adjust) adds 6 to the low nibble when that nibble is above 9 or AC is 1. For example, 7Fh adjusts to 85h.
- R5: During decimal adjust, the upper nibble is tested after the low correction, counting any carry that correction produced. 6 is added to the upper nibble when that value is above 9 or CY is 1. For example, 99h + 99h = 32h with CY=1 and AC=1, which adjusts to 98h.
- R6: Decimal adjust sets CY when the upper correction carries out of bit 7 and otherwise leaves CY unchanged, so it never clears CY. It leaves AC unchanged.
- R7: With valid_i low, or with command code 2'b11, the accumulator, CY and AC keep their values.
- R8: An accepted command's result appears on acc_o, cy_o and ac_o right after the clock edge that samples it. Back-to-back commands chain on the updated state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Command strobe |
| op_i | input | 2 | Command code: 00 add, 01 add with carry, 10 decimal adjust, 11 no effect |
| operand_i | input | 8 | Operand byte for the add commands |
| acc_o | output | 8 | Accumulator |
| cy_o | output | 1 | Carry flag |
| ac_o | output | 1 | Auxiliary carry flag |

## Verification
Directed sequences cover the following cases:
- The known 47h + 38h pair, where only the low nibble exceeds 9.
- A 09h + 08h pair, where only AC forces the low correction.
- A 99h + 99h pair, where both nibbles are corrected through the flags and CY must stay set without a new carry.
- A case where the low correction ripples into an upper nibble of 9.
- The add-with-carry example, with CY set and then with CY clear.

Random commands then mix all four codes with idle cycles and arbitrary operands, including non-BCD bytes. This separates a correct carry chain from one that tests the upper nibble before the low correction. It also separates correct behaviour from a design that clears CY during the adjust or that updates state on idle or reserved cycles.

// File: rtl/bcd_acc_pkg.sv
package bcd_acc_pkg;
  localparam int unsigned NIB_W = 4;

  typedef enum logic [1:0] {
    OP_ADD  = 2'b00,
    OP_ADDC = 2'b01,
    OP_DA   = 2'b10,
    OP_NONE = 2'b11
  } op_e;
endpackage

// File: rtl/bcd_acc_adder.sv
module bcd_acc_adder #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned NIB_W  = 4
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              cin_i,
  output logic [DATA_W-1:0] sum_o,
  output logic              cy_o,
  output logic              ac_o
);
  logic [NIB_W:0]  lo_sum;
  logic [DATA_W:0] full_sum;

  assign lo_sum   = {1'b0, a_i[NIB_W-1:0]} + {1'b0, b_i[NIB_W-1:0]}
                  + {{NIB_W{1'b0}}, cin_i};
  assign full_sum = {1'b0, a_i} + {1'b0, b_i} + {{DATA_W{1'b0}}, cin_i};

  assign sum_o = full_sum[DATA_W-1:0];
  assign cy_o  = full_sum[DATA_W];
  assign ac_o  = lo_sum[NIB_W];
endmodule

// File: rtl/bcd_acc_adjust.sv
module bcd_acc_adjust #(
  parameter int unsigned DIGITS = 2,
  parameter int unsigned NIB_W  = 4,
  localparam int unsigned DATA_W = DIGITS * NIB_W
) (
  input  logic [DATA_W-1:0] acc_i,
  input  logic              ac_i,
  input  logic              cy_i,
  output logic [DATA_W-1:0] acc_o,
  output logic              cy_o
);
  // carry ripples from each digit correction into the next digit's test
  logic [DIGITS:0] chain;
  assign chain[0] = 1'b0;

  for (genvar d = 0; d < DIGITS; d++) begin : g_digit
    logic [NIB_W:0] val;
    logic [NIB_W:0] fixed;
    logic           flag;
    logic           need;

    if (d == 0) begin : g_low
      assign flag = ac_i;
    end else if (d == DIGITS - 1) begin : g_top
      assign flag = cy_i;
    end else begin : g_mid
      assign flag = 1'b0;
    end

    assign val   = {1'b0, acc_i[d*NIB_W +: NIB_W]} + {{NIB_W{1'b0}}, chain[d]};
    assign need  = (val > (NIB_W+1)'(9)) | flag;
    assign fixed = val + (need ? (NIB_W+1)'(6) : (NIB_W+1)'(0));
    assign acc_o[d*NIB_W +: NIB_W] = fixed[NIB_W-1:0];
    assign chain[d+1] = fixed[NIB_W];
  end

  // adjust may only set the carry
  assign cy_o = cy_i | chain[DIGITS];
endmodule

// File: rtl/bcd_acc_regs.sv
module bcd_acc_regs
  import bcd_acc_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  op_e               op_i,
  input  logic [DATA_W-1:0] add_sum_i,
  input  logic              add_cy_i,
  input  logic              add_ac_i,
  input  logic [DATA_W-1:0] adj_acc_i,
  input  logic              adj_cy_i,
  output logic [DATA_W-1:0] acc_q_o,
  output logic              cy_q_o,
  output logic              ac_q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q_o <= '0;
      cy_q_o  <= 1'b0;
      ac_q_o  <= 1'b0;
    end else if (valid_i) begin
      unique case (op_i)
        OP_ADD, OP_ADDC: begin
          acc_q_o <= add_sum_i;
          cy_q_o  <= add_cy_i;
          ac_q_o  <= add_ac_i;
        end
        OP_DA: begin
          acc_q_o <= adj_acc_i;
          cy_q_o  <= adj_cy_i;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/bcd_acc_slice.sv
module bcd_acc_slice
  import bcd_acc_pkg::*;
#(
  parameter int unsigned DIGITS = 2,
  localparam int unsigned DATA_W = DIGITS * NIB_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [1:0]        op_i,
  input  logic [DATA_W-1:0] operand_i,
  output logic [DATA_W-1:0] acc_o,
  output logic              cy_o,
  output logic              ac_o
);
  op_e               op;
  logic [DATA_W-1:0] acc_q;
  logic              cy_q;
  logic              ac_q;
  logic [DATA_W-1:0] add_sum;
  logic              add_cy;
  logic              add_ac;
  logic [DATA_W-1:0] adj_acc;
  logic              adj_cy;
  logic              carry_in;

  assign op       = op_e'(op_i);
  assign carry_in = (op == OP_ADDC) & cy_q;

  bcd_acc_adder #(.DATA_W(DATA_W), .NIB_W(NIB_W)) u_adder (
    .a_i   (acc_q),
    .b_i   (operand_i),
    .cin_i (carry_in),
    .sum_o (add_sum),
    .cy_o  (add_cy),
    .ac_o  (add_ac)
  );

  bcd_acc_adjust #(.DIGITS(DIGITS), .NIB_W(NIB_W)) u_adjust (
    .acc_i (acc_q),
    .ac_i  (ac_q),
    .cy_i  (cy_q),
    .acc_o (adj_acc),
    .cy_o  (adj_cy)
  );

  bcd_acc_regs #(.DATA_W(DATA_W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .valid_i   (valid_i),
    .op_i      (op),
    .add_sum_i (add_sum),
    .add_cy_i  (add_cy),
    .add_ac_i  (add_ac),
    .adj_acc_i (adj_acc),
    .adj_cy_i  (adj_cy),
    .acc_q_o   (acc_q),
    .cy_q_o    (cy_q),
    .ac_q_o    (ac_q)
  );

  assign acc_o = acc_q;
  assign cy_o  = cy_q;
  assign ac_o  = ac_q;
endmodule

// File: rtl/bcd_acc_slice_chk.sv
module bcd_acc_slice_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [1:0]        op_i,
  input logic [DATA_W-1:0] operand_i,
  input logic [DATA_W-1:0] acc_o,
  input logic              cy_o,
  input logic              ac_o
);
  logic is_add, is_da, idle;
  logic lo_big, hi_big;
  assign is_add = valid_i && (op_i == 2'b00);
  assign is_da  = valid_i && (op_i == 2'b10);
  assign idle   = !valid_i || (op_i == 2'b11);
  assign lo_big = acc_o[3:0] > 4'd9;
  assign hi_big = acc_o[DATA_W-1 -: 4] > 4'd9;

  always_comb begin
    if (!rst_ni) begin
      a_r1_reset_clear: assert (acc_o == '0 && !cy_o && !ac_o);
    end
  end

  a_r7_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle |=> ($stable(acc_o) && $stable(cy_o) && $stable(ac_o)));

  a_r2_add_sum: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_add |=> acc_o == DATA_W'($past(acc_o) + $past(operand_i)));

  a_r6_cy_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_da && cy_o) |=> cy_o);

  a_r6_ac_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_da |=> $stable(ac_o));

  a_r4_no_fix_needed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_da && !lo_big && !hi_big && !ac_o && !cy_o) |=> ($stable(acc_o) && !cy_o));
endmodule

bind bcd_acc_slice bcd_acc_slice_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .valid_i   (valid_i),
  .op_i      (op_i),
  .operand_i (operand_i),
  .acc_o     (acc_o),
  .cy_o      (cy_o),
  .ac_o      (ac_o)
);

// File: tb/bcd_acc_slice_tb.sv
module bcd_acc_slice_tb;
  localparam time CLK_P = 4ns;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       valid = 1'b0;
  logic [1:0] op = 2'b11;
  logic [7:0] operand = 8'h00;
  logic [7:0] acc;
  logic       cy, ac;

  int n_chk = 0;
  int n_bad = 0;

  logic [7:0] m_acc = 8'h00;
  logic       m_cy = 1'b0;
  logic       m_ac = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  bcd_acc_slice u_dut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .op_i(op),
    .operand_i(operand), .acc_o(acc), .cy_o(cy), .ac_o(ac)
  );

  // reference model, written from the requirements
  task automatic model_step(input logic v, input logic [1:0] o, input logic [7:0] b);
    logic [8:0] t;
    logic [4:0] lo;
    logic       cin;
    if (!v || o == 2'b11) return;
    if (o == 2'b10) begin
      t = {1'b0, m_acc};
      if (t[3:0] > 4'd9 || m_ac) t = t + 9'h006;
      if (t[8:4] > 5'd9 || m_cy) t = t + 9'h060;
      m_cy  = m_cy | t[8];
      m_acc = t[7:0];
    end else begin
      cin  = (o == 2'b01) ? m_cy : 1'b0;
      lo   = {1'b0, m_acc[3:0]} + {1'b0, b[3:0]} + {4'd0, cin};
      t    = {1'b0, m_acc} + {1'b0, b} + {8'd0, cin};
      m_ac = lo[4];
      m_cy = t[8];
      m_acc = t[7:0];
    end
  endtask

  function automatic string req_of(input logic v, input logic [1:0] o);
    if (!v || o == 2'b11) return "R7";
    case (o)
      2'b00:   return "R2";
      2'b01:   return "R3";
      default: return "R4/R5/R6";
    endcase
  endfunction

  task automatic compare(input string req, input logic [7:0] e_acc, input logic e_cy, input logic e_ac);
    n_chk++;
    if (acc !== e_acc || cy !== e_cy || ac !== e_ac) begin
      n_bad++;
      $display("FAIL %s: acc=%02h cy=%0b ac=%0b expected acc=%02h cy=%0b ac=%0b",
               req, acc, cy, ac, e_acc, e_cy, e_ac);
    end
  endtask

  // drive at negedge, result checked at the following negedge (R8)
  task automatic step(input logic v, input logic [1:0] o, input logic [7:0] b);
    valid = v; op = o; operand = b;
    model_step(v, o, b);
    @(negedge clk);
    compare({req_of(v, o), " R8"}, m_acc, m_cy, m_ac);
  endtask

  task automatic load(input logic [7:0] val);
    step(1'b1, 2'b00, val - m_acc);
  endtask

  initial begin
    #(CLK_P * 200000);
    n_bad++;
    $display("FAIL watchdog: timeout");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h1b2c_3d4e));
    @(negedge clk);
    compare("R1", 8'h00, 1'b0, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    compare("R1", 8'h00, 1'b0, 1'b0);

    // R3: 05h + 03h + CY(1) -> 09h
    step(1'b1, 2'b00, 8'h80);
    step(1'b1, 2'b00, 8'h85);
    compare("R2", 8'h05, 1'b1, 1'b0);
    step(1'b1, 2'b01, 8'h03);
    compare("R3", 8'h09, 1'b0, 1'b0);
    step(1'b1, 2'b01, 8'h03);
    compare("R3", 8'h0C, 1'b0, 1'b0);

    // R4: 47h + 38h = 7Fh -> 85h
    load(8'h47);
    step(1'b1, 2'b00, 8'h38);
    compare("R2", 8'h7F, 1'b0, 1'b0);
    step(1'b1, 2'b10, 8'h00);
    compare("R4", 8'h85, 1'b0, 1'b0);

    // R4: AC-only low fix, 09h + 08h = 11h -> 17h
    load(8'h09);
    step(1'b1, 2'b00, 8'h08);
    step(1'b1, 2'b10, 8'h00);
    compare("R4", 8'h17, 1'b0, 1'b1);

    // R5/R6: 99h + 99h = 32h CY=1 AC=1 -> 98h, CY kept
    load(8'h99);
    step(1'b1, 2'b00, 8'h99);
    compare("R2", 8'h32, 1'b1, 1'b1);
    step(1'b1, 2'b10, 8'h00);
    compare("R5", 8'h98, 1'b1, 1'b1);

    // R5: low fix ripples into upper 9 -> 9Ah -> A0h -> 00h, CY set
    load(8'h00);
    load(8'h9A);
    step(1'b1, 2'b10, 8'h00);
    compare("R6", 8'h00, 1'b1, m_ac);

    // R7: idle and reserved code do nothing
    step(1'b0, 2'b00, 8'h55);
    step(1'b1, 2'b11, 8'hAA);
    compare("R7", 8'h00, 1'b1, m_ac);

    for (int i = 0; i < 4000; i++) begin
      logic       v;
      logic [1:0] o;
      v = ($urandom % 5) != 0;
      o = 2'($urandom);
      step(v, o, 8'($urandom));
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule